// File: doc/BRIEF.md
# Latched Serial-to-Parallel Register

This block turns a serial bit stream into a parallel word through two register stages. A shift stage takes one bit on every rising edge of its shift clock and moves the bits it already holds one place along. A separate storage stage is loaded with the whole shift stage on a rising edge of a second clock, the store clock. The parallel outputs show only the storage stage. They therefore keep their old value while a new word is being shifted in, and all bits change together when the word is stored.

The last shift stage drives a serial cascade output. Tie it to the serial input of a second instance that shares both clocks, and the pair behaves as one register of twice the width. An active-low clear empties the shift stage at once, without waiting for a clock edge, and leaves the storage stage alone. An active-low output enable produces a per-bit enable vector beside the parallel value. This stands in for three-state pins.

The serial input has no valid/ready handshake and applies no back-pressure. Each rising shift-clock edge takes the bit present on the serial input, so the driver decides the pace. The storage stage can be loaded at any time, and a load never stalls the shift stage.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising `shift_clk` edge with `clr_n` high, shift bit 0 takes `ser_in` and each shift bit k (k >= 1) takes the old shift bit k-1.
- R2: `ser_out` equals the shift bit at index W-1, the bit shifted in W edges earlier. `oe_n` does not affect it.
- R3: On a rising `store_clk` edge the storage stage copies the shift stage. `par_q[i]` then equals shift bit i, so a word shifted in MSB first appears with its MSB on `par_q[W-1]`.
- R4: Shift-clock edges and new serial data never change `par_q`. Only a `store_clk` edge changes it.
- R5: With `oe_n` low, `par_en` is all ones. With `oe_n` high, `par_en` is all zeros. In the default hold mode, `par_q` keeps the stored value whatever `oe_n` is.
- R6: Driving `clr_n` low sets the shift stage to zero right away, without a clock edge, so `ser_out` reads 0 while `clr_n` is low.
- R7: A clear leaves the storage stage and `par_q` unchanged. The first `store_clk` edge after the clear makes `par_q` all zeros.
- R8: Two instances are chained through `ser_out`, with shared clocks, clear and enable. After 2·W shift edges and one store edge, the downstream instance shows the first W bits sent and the upstream instance shows the last W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data bit, taken on the rising shift_clk edge |
| shift_clk | input | 1 | Shift stage clock, rising edge |
| store_clk | input | 1 | Storage stage clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the shift stage |
| oe_n | input | 1 | Active-low parallel output enable |
| par_q | output | W | Parallel value from the storage stage |
| par_en | output | W | Per-bit drive enable; 0 means high impedance |
| ser_out | output | 1 | Cascade output from the last shift bit |

## Verification
Two events can fall together and must not interfere. The first is a store edge arriving while a new word is being shifted in: the outputs must freeze on the stored word while shifting carries on. The second is a clear landing between shift edges: the serial path must drop to zero while the stored word stays. The bench sweeps every 8-bit value through a chain of two instances and checks each stored word. It then shifts fresh data behind the stored word and checks that the parallel outputs stay fixed. Finally it pulses the clear between edges and confirms that the cascade output reads zero while the outputs keep the old word until the next store edge.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Default register width
  localparam int unsigned SIPO_WIDTH = 8;

  // What the parallel value does while the enable vector is off
  typedef enum logic {
    GATE_HOLD = 1'b0,  // value keeps the storage content
    GATE_ZERO = 1'b1   // value is forced low
  } gate_mode_e;

endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         shift_clk,
  input  logic         clr_n,
  input  logic         ser_in,
  output logic [W-1:0] sh_q,
  output logic         ser_out
);

  localparam int unsigned LAST = W - 1;

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[LAST-1:0], ser_in};
    end
  end

  assign ser_out = sh_q[LAST];

endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
  parameter int unsigned W = 8
) (
  input  logic         store_clk,
  input  logic [W-1:0] sh_q,
  output logic [W-1:0] st_q
);

  // Storage has no clear; only a store edge changes it
  always_ff @(posedge store_clk) begin
    st_q <= sh_q;
  end

endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate
  import sipo_pkg::*;
#(
  parameter int unsigned W    = 8,
  parameter gate_mode_e  MODE = GATE_HOLD
) (
  input  logic         oe_n,
  input  logic [W-1:0] st_q,
  output logic [W-1:0] par_q,
  output logic [W-1:0] par_en
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign par_en[i] = ~oe_n;
    if (MODE == GATE_ZERO) begin : g_zero
      assign par_q[i] = st_q[i] & ~oe_n;
    end else begin : g_hold
      assign par_q[i] = st_q[i];
    end
  end

endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg
  import sipo_pkg::*;
#(
  parameter int unsigned W    = SIPO_WIDTH,
  parameter gate_mode_e  MODE = GATE_HOLD
) (
  input  logic         ser_in,
  input  logic         shift_clk,
  input  logic         store_clk,
  input  logic         clr_n,
  input  logic         oe_n,
  output logic [W-1:0] par_q,
  output logic [W-1:0] par_en,
  output logic         ser_out
);

  logic [W-1:0] sh_q;
  logic [W-1:0] st_q;

  sipo_shift_stage #(.W(W)) u_shift (
    .shift_clk (shift_clk),
    .clr_n     (clr_n),
    .ser_in    (ser_in),
    .sh_q      (sh_q),
    .ser_out   (ser_out)
  );

  sipo_store_stage #(.W(W)) u_store (
    .store_clk (store_clk),
    .sh_q      (sh_q),
    .st_q      (st_q)
  );

  sipo_out_gate #(.W(W), .MODE(MODE)) u_gate (
    .oe_n   (oe_n),
    .st_q   (st_q),
    .par_q  (par_q),
    .par_en (par_en)
  );

endmodule

// File: rtl/sipo_latch_reg_chk.sv
module sipo_latch_reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk,
  input logic         store_clk,
  input logic         clr_n,
  input logic         oe_n,
  input logic         ser_in,
  input logic         ser_out,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] st_q,
  input logic [W-1:0] par_en
);

  // Set once a shift edge has passed since the last clear
  logic armed = 1'b0;
  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // Last word the storage stage was loaded with
  logic         loaded = 1'b0;
  logic [W-1:0] last_load = '0;
  always_ff @(posedge store_clk) begin
    loaded    <= 1'b1;
    last_load <= sh_q;
  end

  // R1
  shift_move_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    armed |-> sh_q == {$past(sh_q[W-2:0]), $past(ser_in)});

  // R2
  cascade_tap_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    armed |-> ser_out == $past(sh_q[W-2]));

  // R4
  store_hold_chk: assert property (@(posedge shift_clk)
    loaded |-> st_q == last_load);

  // R5
  enable_off_chk: assert property (@(posedge shift_clk)
    oe_n |-> par_en == '0);

  // R5
  enable_on_chk: assert property (@(posedge shift_clk)
    !oe_n |-> &par_en);

  // R6
  clear_zero_chk: assert property (@(posedge shift_clk)
    !clr_n |-> (sh_q == '0 && !ser_out));

endmodule

bind sipo_latch_reg sipo_latch_reg_chk #(.W(W)) u_chk (
  .shift_clk (shift_clk),
  .store_clk (store_clk),
  .clr_n     (clr_n),
  .oe_n      (oe_n),
  .ser_in    (ser_in),
  .ser_out   (ser_out),
  .sh_q      (sh_q),
  .st_q      (st_q),
  .par_en    (par_en)
);

// File: tb/sipo_latch_reg_test.sv
module sipo_latch_reg_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int HALF       = CLK_PERIOD / 2;

  logic         ser_in    = 1'b0;
  logic         shift_clk = 1'b0;
  logic         store_clk = 1'b0;
  logic         clr_n     = 1'b0;
  logic         oe_n      = 1'b1;
  logic [W-1:0] par_q_a, par_en_a, par_q_b, par_en_b;
  logic         ser_a, ser_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // upstream instance
  sipo_latch_reg #(.W(W)) uut (
    .ser_in (ser_in), .shift_clk (shift_clk), .store_clk (store_clk),
    .clr_n (clr_n), .oe_n (oe_n),
    .par_q (par_q_a), .par_en (par_en_a), .ser_out (ser_a)
  );

  // downstream instance fed by the cascade output
  sipo_latch_reg #(.W(W)) uut_dn (
    .ser_in (ser_a), .shift_clk (shift_clk), .store_clk (store_clk),
    .clr_n (clr_n), .oe_n (oe_n),
    .par_q (par_q_b), .par_en (par_en_b), .ser_out (ser_b)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    #HALF shift_clk = 1'b1;
    #HALF shift_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int k = W - 1; k >= 0; k--) shift_bit(w[k]);
  endtask

  task automatic store_pulse();
    #HALF store_clk = 1'b1;
    #HALF store_clk = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    // reset state: clear held, store zeros
    #HALF;
    store_pulse();
    #1;
    check("R7 reset store", par_q_a, '0);
    check("R7 reset store dn", par_q_b, '0);
    check("R6 reset ser_out", {7'd0, ser_a}, '0);
    check("R5 disabled", par_en_a, '0);
    clr_n = 1'b1;
    #HALF;

    for (int v = 0; v < 256; v++) begin
      a = W'(v);
      b = W'((v * 37 + 11) % 256);
      oe_n = v[0];
      shift_word(b);               // first word goes downstream
      #1 check("R2 cascade after W", {7'd0, ser_a}, {7'd0, b[W-1]});
      shift_word(a);
      #1;
      check("R2 cascade dn", {7'd0, ser_b}, {7'd0, b[W-1]});
      check("R1 shifted tap", {7'd0, ser_a}, {7'd0, a[W-1]});
      store_pulse();
      #1;
      check("R8 upstream word", par_q_a, a);
      check("R8 downstream word", par_q_b, b);
      check("R3 store copy", par_q_a, a);
      check("R5 enable vec", par_en_a, v[0] ? '0 : '1);
      check("R5 enable vec dn", par_en_b, v[0] ? '0 : '1);
      // new data shifted behind the stored word
      shift_word(~a);
      #1;
      check("R4 hold during shift", par_q_a, a);
      check("R4 hold during shift dn", par_q_b, b);
      if (v % 16 == 5) begin
        #HALF clr_n = 1'b0;
        #1;
        check("R6 async clear", {7'd0, ser_a}, '0);
        check("R7 storage kept", par_q_a, a);
        check("R7 storage kept dn", par_q_b, b);
        #HALF clr_n = 1'b1;
        store_pulse();
        #1;
        check("R7 zeros after store", par_q_a, '0);
        check("R7 zeros after store dn", par_q_b, '0);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule